// File: doc/BRIEF.md
# Four-Channel Bidirectional Command/Data Mailbox

This block lets a cluster of application cores (side A) and a small control processor (side B) pass short requests to each other over four independent channels. Each direction has, for every channel, a command word and a data word, plus a direction-wide interrupt-enable vector and a pending-status vector. A sender writes the command word of a channel and then its data word. The data write marks that channel pending in the sender's direction, and the receiver sees an interrupt on that channel if it has enabled it.

Each side has a simple word-addressed register port with a write strobe, a byte address, write data and combinational read data. Both ports see the same address map and can read every register. Writes follow fixed ownership rules. A side writes the payload registers of its own outgoing direction. It writes the enable and status registers of its incoming direction, and acknowledges a message by writing ones to that status register. Every other write is dropped. Side A gets one interrupt line per channel. Side B gets a matching vector for the other direction.

Top module: `dual_mailbox`

## Requirements
- R1: While reset (rstN low) is applied, every register is forced to zero. Every register reads 0 afterwards and both interrupt vectors are low.
- R2: Outgoing registers of side A: channel n's command word sits at byte offset 0x08+8n and its data word at 0x0C+8n. Only the side A port writes them, and both ports read back the stored 32-bit value.
- R3: Outgoing registers of side B: channel n's command word sits at 0x30+8n and its data word at 0x34+8n. Only the side B port writes them, and both ports read back the stored value.
- R4: A write to channel n's data word sets bit n of that direction's status register on the next clock. The status register for side A's outgoing direction is at 0x04 and the one for side B's outgoing direction is at 0x2C. A write to the command word alone leaves status unchanged.
- R5: A status register is write-one-to-clear, written only by the receiving side: side B for 0x04, side A for 0x2C. Bit n is cleared where the written value has a 1, and bits written with 0 keep their value.
- R6: If a data write sets status bit n in the same cycle that a write-one-to-clear hits bit n, the bit ends up set.
- R7: The enable register of side A's outgoing direction is at 0x00 and only side B writes it. The enable register of side B's outgoing direction is at 0x28 and only side A writes it. Only the low four bits are stored and the upper bits read 0, so writing 0xFF reads back 0xF.
- R8: irqToA[n] is high exactly when bit n of the 0x2C status and bit n of the 0x28 enable are both set. irqToB[n] follows the same rule with 0x04 and 0x00. Clearing an enable bit drops the interrupt but keeps the status bit.
- R9: A write from either port to a register that port does not own has no effect on any register.
- R10: Offsets at or beyond 0x50, and offsets whose two low bits are not zero, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| aWrEn | input | 1 | Side A write strobe |
| aAddr | input | 8 | Side A byte address (read and write) |
| aWdata | input | 32 | Side A write data |
| aRdata | output | 32 | Side A read data, combinational from aAddr |
| bWrEn | input | 1 | Side B write strobe |
| bAddr | input | 8 | Side B byte address (read and write) |
| bWdata | input | 32 | Side B write data |
| bRdata | output | 32 | Side B read data, combinational from bAddr |
| irqToA | output | 4 | Per-channel interrupts toward side A |
| irqToB | output | 4 | Per-channel interrupts toward side B |

## Verification
The bound checker watches several rules on every clock. A data write must leave its status bit set on the next cycle, and a set must win over a simultaneous clear. A clear must remove exactly the bits written as ones. Interrupts must hold still in any cycle without a write, side A writes must never disturb the status of side A's outgoing direction, and reset must leave everything zero. The bench scenarios cover what a cycle-local property cannot reach: the stored values read back across ports, the address map and its aliasing edges, the upper enable bits reading zero, and the effect of enable on the interrupt lines.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Register kinds inside one direction's window
  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_EN   = 3'd1,
    K_STS  = 3'd2,
    K_CMD  = 3'd3,
    K_DATA = 3'd4
  } regKind_e;

  // Decoded address of one port
  typedef struct packed {
    logic     hit;
    logic     dir;   // 0: side A outgoing, 1: side B outgoing
    regKind_e kind;
    logic [7:0] ch;
  } regSel_t;

  // Write strobes for one direction's register set
  typedef struct packed {
    logic       cmdWr;
    logic       dataWr;
    logic       enWr;
    logic       stsClr;
    logic [7:0] ch;
  } dirStrobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic [1:0]         wrEn,
  input  logic [1:0][AW-1:0] addr,
  output regSel_t [1:0]      sel,
  output dirStrobe_t [1:0]   dirStr
);

  localparam int SPAN = 8 + 8 * NCH;
  localparam logic [AW-1:0] SPAN_A = AW'(SPAN);
  localparam logic [AW-1:0] END_A  = AW'(2 * SPAN);

  function automatic regSel_t decodeAddr(input logic [AW-1:0] a);
    regSel_t r;
    logic [AW-1:0] off;
    logic [AW-1:0] slot;
    r.hit  = 1'b0;
    r.dir  = 1'b0;
    r.kind = K_NONE;
    r.ch   = '0;
    off    = '0;
    slot   = '0;
    if (a[1:0] == 2'b00 && a < END_A) begin
      r.hit = 1'b1;
      r.dir = (a >= SPAN_A);
      off   = r.dir ? (a - SPAN_A) : a;
      if (off == AW'(0)) begin
        r.kind = K_EN;
      end else if (off == AW'(4)) begin
        r.kind = K_STS;
      end else begin
        slot   = (off - AW'(8)) >> 3;
        r.ch   = 8'(slot);
        r.kind = off[2] ? K_DATA : K_CMD;
      end
    end
    return r;
  endfunction

  for (genvar p = 0; p < 2; p++) begin : gDec
    assign sel[p] = decodeAddr(addr[p]);
  end

  // Direction d: payload owned by port d, enable/status owned by port 1-d
  for (genvar d = 0; d < 2; d++) begin : gStr
    localparam int CP = 1 - d;
    dirStrobe_t s;
    logic payHit, ctlHit;
    always_comb begin
      payHit   = wrEn[d]  && sel[d].hit  && (sel[d].dir  == 1'(d));
      ctlHit   = wrEn[CP] && sel[CP].hit && (sel[CP].dir == 1'(d));
      s.cmdWr  = payHit && (sel[d].kind == K_CMD);
      s.dataWr = payHit && (sel[d].kind == K_DATA);
      s.ch     = sel[d].ch;
      s.enWr   = ctlHit && (sel[CP].kind == K_EN);
      s.stsClr = ctlHit && (sel[CP].kind == K_STS);
    end
    assign dirStr[d] = s;
  end

endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dirStrobe_t [1:0]      dirStr,
  input  logic [1:0][DW-1:0]    portWdata,
  input  regSel_t [1:0]         sel,
  output logic [1:0][DW-1:0]    portRdata,
  output logic [1:0][NCH-1:0]   stsOut,
  output logic [1:0][NCH-1:0]   irqVec
);

  logic [1:0][DW-1:0] rdDir [2];

  for (genvar d = 0; d < 2; d++) begin : gDir
    localparam int CP = 1 - d;
    logic [DW-1:0]      cmdQ [NCH];
    logic [DW-1:0]      datQ [NCH];
    logic [NCH-1:0]     enQ, stsQ, chHot, setV, clrV;
    logic [DW-1:0]      payW;
    logic [NCH-1:0]     ctlW;
    logic [1:0][DW-1:0] rdHere;

    assign payW = portWdata[d];
    assign ctlW = portWdata[CP][NCH-1:0];

    always_comb begin
      for (int i = 0; i < NCH; i++) chHot[i] = (dirStr[d].ch == 8'(i));
    end

    assign setV = dirStr[d].dataWr ? chHot : '0;
    assign clrV = dirStr[d].stsClr ? ctlW : '0;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < NCH; i++) begin
          cmdQ[i] <= '0;
          datQ[i] <= '0;
        end
        enQ  <= '0;
        stsQ <= '0;
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (dirStr[d].cmdWr && chHot[i])  cmdQ[i] <= payW;
          if (dirStr[d].dataWr && chHot[i]) datQ[i] <= payW;
        end
        if (dirStr[d].enWr) enQ <= ctlW;
        stsQ <= (stsQ & ~clrV) | setV;   // set wins over clear
      end
    end

    always_comb begin
      for (int p = 0; p < 2; p++) begin
        rdHere[p] = '0;
        case (sel[p].kind)
          K_EN:    rdHere[p] = DW'(enQ);
          K_STS:   rdHere[p] = DW'(stsQ);
          K_CMD:   for (int i = 0; i < NCH; i++) if (sel[p].ch == 8'(i)) rdHere[p] = cmdQ[i];
          K_DATA:  for (int i = 0; i < NCH; i++) if (sel[p].ch == 8'(i)) rdHere[p] = datQ[i];
          default: rdHere[p] = '0;
        endcase
      end
    end

    assign rdDir[d]  = rdHere;
    assign stsOut[d] = stsQ;
    assign irqVec[d] = enQ & stsQ;
  end

  always_comb begin
    for (int p = 0; p < 2; p++)
      portRdata[p] = sel[p].hit ? rdDir[sel[p].dir][p] : '0;
  end

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           aWrEn,
  input  logic [AW-1:0]  aAddr,
  input  logic [DW-1:0]  aWdata,
  output logic [DW-1:0]  aRdata,
  input  logic           bWrEn,
  input  logic [AW-1:0]  bAddr,
  input  logic [DW-1:0]  bWdata,
  output logic [DW-1:0]  bRdata,
  output logic [NCH-1:0] irqToA,
  output logic [NCH-1:0] irqToB
);

  logic [1:0]           wrEn;
  logic [1:0][AW-1:0]   addr;
  logic [1:0][DW-1:0]   wdata, rdata;
  regSel_t [1:0]        sel;
  dirStrobe_t [1:0]     dirStr;
  logic [1:0][NCH-1:0]  stsAll, irqVec;

  assign wrEn  = {bWrEn, aWrEn};
  assign addr  = {bAddr, aAddr};
  assign wdata = {bWdata, aWdata};

  mbox_ctrl #(.NCH(NCH), .AW(AW)) uCtrl (
    .wrEn(wrEn), .addr(addr), .sel(sel), .dirStr(dirStr)
  );

  mbox_dpath #(.NCH(NCH), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .dirStr(dirStr), .portWdata(wdata),
    .sel(sel), .portRdata(rdata), .stsOut(stsAll), .irqVec(irqVec)
  );

  assign aRdata = rdata[0];
  assign bRdata = rdata[1];
  assign irqToB = irqVec[0];
  assign irqToA = irqVec[1];

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 aWrEn,
  input logic [AW-1:0]        aAddr,
  input logic                 bWrEn,
  input logic [AW-1:0]        bAddr,
  input logic [NCH-1:0]       bClrBits,
  input logic [NCH-1:0]       irqToA,
  input logic [NCH-1:0]       irqToB,
  input logic [1:0][NCH-1:0]  stsAll
);

  localparam int SPAN = 8 + 8 * NCH;
  localparam logic [AW-1:0] SPAN_A = AW'(SPAN);
  localparam logic [AW-1:0] END_A  = AW'(2 * SPAN);

  logic [AW-1:0]  aSlot, bSlot;
  logic [NCH-1:0] aHot, bHot, aHotQ, bHotQ, clrQ;
  logic           aDataA2B, bDataB2A, bClrA2B;

  assign aDataA2B = aWrEn && aAddr[2:0] == 3'b100 && aAddr >= AW'(8) && aAddr < SPAN_A;
  assign bDataB2A = bWrEn && bAddr[2:0] == 3'b100 && bAddr >= SPAN_A + AW'(8) && bAddr < END_A;
  assign bClrA2B  = bWrEn && bAddr == AW'(4);
  assign aSlot    = (aAddr - AW'(8)) >> 3;
  assign bSlot    = (bAddr - SPAN_A - AW'(8)) >> 3;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      aHot[i] = (aSlot == AW'(i));
      bHot[i] = (bSlot == AW'(i));
    end
  end

  always_ff @(posedge clk) begin
    aHotQ <= aHot;
    bHotQ <= bHot;
    clrQ  <= bClrBits;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |=> (stsAll == '0 && irqToA == '0 && irqToB == '0));

  // R4
  a2b_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    aDataA2B |=> (stsAll[0] & aHotQ) == aHotQ);

  // R4
  b2a_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    bDataB2A |=> (stsAll[1] & bHotQ) == bHotQ);

  // R5
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    bClrA2B && !aDataA2B |=> (stsAll[0] & clrQ) == '0);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    bClrA2B && aDataA2B && ((bClrBits & aHot) != '0) |=> (stsAll[0] & aHotQ) != '0);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aWrEn && !bWrEn |=> $stable(irqToA) && $stable(irqToB));

  // R9
  a_no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    aWrEn && !bWrEn && !aDataA2B |=> $stable(stsAll[0]));

endmodule

bind dual_mailbox mbox_chk #(.NCH(NCH), .AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .aWrEn(aWrEn), .aAddr(aAddr),
  .bWrEn(bWrEn), .bAddr(bAddr), .bClrBits(bWdata[NCH-1:0]),
  .irqToA(irqToA), .irqToB(irqToB), .stsAll(stsAll)
);

// File: tb/dual_mailbox_test.sv
`timescale 1ns/1ps
module dual_mailbox_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        aWrEn = 1'b0, bWrEn = 1'b0;
  logic [7:0]  aAddr = '0, bAddr = '0;
  logic [31:0] aWdata = '0, bWdata = '0;
  logic [31:0] aRdata, bRdata;
  logic [3:0]  irqToA, irqToB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  dual_mailbox uut (
    .clk(clk), .rstN(rstN),
    .aWrEn(aWrEn), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bWrEn(bWrEn), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata),
    .irqToA(irqToA), .irqToB(irqToB)
  );

  // {wrPort, wrAddr, wrData, rdPort, rdAddr, expected, tag}; port 0 = A, 1 = B
  localparam int NV = 14;
  localparam logic [113:0] VEC [NV] = '{
    {1'b0, 8'h08, 32'hC0DE0000, 1'b1, 8'h08, 32'hC0DE0000, "R2  "},
    {1'b0, 8'h0C, 32'h11110000, 1'b1, 8'h04, 32'h00000001, "R4  "},
    {1'b0, 8'h20, 32'h33330003, 1'b0, 8'h04, 32'h00000001, "R4  "},
    {1'b0, 8'h24, 32'h00000044, 1'b1, 8'h04, 32'h00000009, "R4  "},
    {1'b1, 8'h00, 32'h000000FF, 1'b0, 8'h00, 32'h0000000F, "R7  "},
    {1'b1, 8'h04, 32'h00000001, 1'b1, 8'h04, 32'h00000008, "R5  "},
    {1'b1, 8'h30, 32'h0000BEEF, 1'b0, 8'h30, 32'h0000BEEF, "R3  "},
    {1'b1, 8'h44, 32'h00002222, 1'b0, 8'h2C, 32'h00000004, "R3  "},
    {1'b0, 8'h28, 32'h00000004, 1'b1, 8'h28, 32'h00000004, "R7  "},
    {1'b0, 8'h30, 32'h0000DEAD, 1'b0, 8'h30, 32'h0000BEEF, "R9  "},
    {1'b1, 8'h08, 32'h0000DEAD, 1'b0, 8'h08, 32'hC0DE0000, "R9  "},
    {1'b0, 8'h04, 32'h0000000F, 1'b0, 8'h04, 32'h00000008, "R9  "},
    {1'b0, 8'h60, 32'h00000005, 1'b0, 8'h60, 32'h00000000, "R10 "},
    {1'b0, 8'h0E, 32'h00000001, 1'b0, 8'h04, 32'h00000008, "R10 "}
  };

  task automatic check(input logic [31:0] tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit port, input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (port) begin bWrEn = 1'b1; bAddr = ad; bWdata = d; end
    else      begin aWrEn = 1'b1; aAddr = ad; aWdata = d; end
    @(negedge clk);
    aWrEn = 1'b0;
    bWrEn = 1'b0;
  endtask

  task automatic rd(input bit port, input logic [7:0] ad, output logic [31:0] v);
    if (port) bAddr = ad; else aAddr = ad;
    #1;
    v = port ? bRdata : aRdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    logic [113:0] v;
    logic [31:0]  r;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(1'b0, 8'h08, r); check("R1  ", r, 32'h0);
    rd(1'b1, 8'h2C, r); check("R1  ", r, 32'h0);
    rd(1'b0, 8'h34, r); check("R1  ", r, 32'h0);
    check("R1  ", {28'b0, irqToA}, 32'h0);
    check("R1  ", {28'b0, irqToB}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      wr(v[113], v[112:105], v[104:73]);
      rd(v[72], v[71:64], r);
      check(v[31:0], r, v[63:32]);
    end

    // R8: interrupts from status AND enable
    check("R8  ", {28'b0, irqToA}, 32'h4);
    check("R8  ", {28'b0, irqToB}, 32'h8);

    // R5: side A acknowledges channel 2 of side B's direction
    wr(1'b0, 8'h2C, 32'h4);
    rd(1'b1, 8'h2C, r); check("R5  ", r, 32'h0);
    check("R5  ", {28'b0, irqToA}, 32'h0);

    // R8: disable drops the interrupt, status is kept
    wr(1'b1, 8'h00, 32'h0);
    check("R8  ", {28'b0, irqToB}, 32'h0);
    rd(1'b1, 8'h04, r); check("R8  ", r, 32'h8);

    // R6: set and clear of bit 1 in the same cycle
    @(negedge clk);
    aWrEn = 1'b1; aAddr = 8'h14; aWdata = 32'h77;
    bWrEn = 1'b1; bAddr = 8'h04; bWdata = 32'h2;
    @(negedge clk);
    aWrEn = 1'b0; bWrEn = 1'b0;
    rd(1'b1, 8'h04, r); check("R6  ", r, 32'hA);
    rd(1'b1, 8'h14, r); check("R2  ", r, 32'h77);
    rd(1'b1, 8'h44, r); check("R3  ", r, 32'h2222);
    rd(1'b0, 8'h24, r); check("R2  ", r, 32'h44);

    // R10: unmapped reads
    rd(1'b0, 8'h50, r); check("R10 ", r, 32'h0);
    rd(1'b1, 8'h0E, r); check("R10 ", r, 32'h0);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    rd(1'b0, 8'h08, r); check("R1  ", r, 32'h0);
    rd(1'b1, 8'h30, r); check("R1  ", r, 32'h0);
    rd(1'b1, 8'h04, r); check("R1  ", r, 32'h0);
    rd(1'b0, 8'h28, r); check("R1  ", r, 32'h0);

    done = 1'b1;
    summary();
  end

endmodule